// File: doc/BRIEF.md
# Four-Phase Oversampled Bit Aligner

This block recovers one serial lane of a source-synchronous link in which every edge of the forwarded clock carries one bit. A front end, not part of this block, captures each bit period at four equally spaced phases. The block receives those four samples as a frame in the internal clock domain, one frame per accepted cycle. It learns where the data transitions fall among the four phases and picks the sample phase that lies half a bit away from the busiest transition position, which is the middle of the eye. The chosen samples go on to the deskew stage.

The block decides only at the end of each window of accepted frames and moves the sample phase by at most one position per decision, so total jitter of up to about one bit period cannot make the selection chase individual edges. When the selection crosses the bit boundary, the output emits zero or two bits in one cycle. This keeps the recovered stream free of dropped or repeated bits.

Top module: `os4_bit_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `phase_o` equals the parameter `INIT_PH` (default 2), `bit_cnt_o` is 0 and `bit_vld_o` is 0.
- R2: For every accepted frame except the first after reset, one transition is counted at position 0 if phase 3 of the previous frame differs from phase 0 of this frame. One is also counted at each position k in 1..3 if phase k-1 differs from phase k of this frame. The counts accumulate over `WIN` counted frames and then restart.
- R3: At the end of each window, the target phase is (p + 2) mod 4, where p is the position with the most transitions. On a tie the lowest position wins.
- R4: At a window end, `phase_o` steps by one position toward the target, wrapping modulo 4. If the target is two positions away, it steps up by one. `phase_o` changes only at window ends, and the new value is visible in the cycle after the last frame of the window.
- R5: A window with no transitions at any position leaves `phase_o` unchanged.
- R6: Each accepted frame, except the first after reset, produces an output in the next cycle. That output is built from the previous accepted frame F and the value of `phase_o` before this cycle. Normally `bit_cnt_o` is 1 and `bit_o[0]` is sample `phase_o` of F.
- R7: On the first output after `phase_o` has moved from 3 to 0, `bit_cnt_o` is 0 and no bit is emitted.
- R8: On the first output after `phase_o` has moved from 0 to 3, `bit_cnt_o` is 2. `bit_o[0]` is phase 3 of the frame before F (the earlier bit) and `bit_o[1]` is phase 3 of F.
- R9: A cycle with `ph_vld_i` low gives `bit_cnt_o` = 0 in the next cycle and changes neither `phase_o` nor the transition counts.
- R10: `bit_vld_o` is 1 exactly when `bit_cnt_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_vld_i | input | 1 | A new four-phase frame is present |
| ph_smp_i | input | 4 | Samples of one bit period, bit 0 earliest phase |
| bit_o | output | 2 | Recovered bits, bit 0 earlier in time |
| bit_cnt_o | output | 2 | Number of valid bits in `bit_o` (0, 1 or 2) |
| bit_vld_o | output | 1 | At least one recovered bit is present |
| phase_o | output | 2 | Currently selected sample phase |

## Verification
A wrong transition count or a wrong tie rule does not show at once. It appears at the next window end, up to `WIN` accepted frames later, when `phase_o` settles on a phase other than the one the edge histogram implies. After that, every output bit is taken from the wrong sample. A fault in the wrap handling shows in the very next output after a 3-to-0 or 0-to-3 move, as a wrong `bit_cnt_o` or a repeated or missing bit. The bench therefore drives clean edges at each of the four positions, walks the phase through both boundary crossings, and feeds jittered random traffic with idle gaps. It compares every output cycle against a frame-level model.

// File: rtl/os4_pkg.sv
package os4_pkg;
   localparam int NPH = 4;
   typedef logic [1:0] ph_t;

   // one step toward tgt modulo NPH; an opposite target steps upward
   function automatic ph_t ph_step(input ph_t cur, input ph_t tgt);
      ph_t d;
      d = ph_t'(tgt - cur);
      case (d)
         2'd0:    ph_step = cur;
         2'd3:    ph_step = ph_t'(cur - 2'd1);
         default: ph_step = ph_t'(cur + 2'd1);
      endcase
   endfunction
endpackage

// File: rtl/os4_edge_tally.sv
module os4_edge_tally #(
   parameter int WIN = 64,
   parameter int CW  = $clog2(WIN + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              tally_i,
   input  logic [os4_pkg::NPH-1:0]           cur_i,
   input  logic                              prev3_i,
   output logic                              win_end_o,
   output logic [os4_pkg::NPH-1:0][CW-1:0]   sum_o
);
   localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

   logic [WW-1:0]                         wcnt_q;
   logic [os4_pkg::NPH-1:0]               edge_w;
   logic [os4_pkg::NPH-1:0][CW-1:0]       acc_q;

   assign edge_w[0] = prev3_i ^ cur_i[0];
   assign win_end_o = tally_i && (wcnt_q == WW'(WIN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)          wcnt_q <= '0;
      else if (win_end_o)  wcnt_q <= '0;
      else if (tally_i)    wcnt_q <= wcnt_q + WW'(1);
   end

   genvar k;
   generate
      for (k = 1; k < os4_pkg::NPH; k++) begin : g_edge
         assign edge_w[k] = cur_i[k-1] ^ cur_i[k];
      end
      for (k = 0; k < os4_pkg::NPH; k++) begin : g_acc
         assign sum_o[k] = acc_q[k] + CW'(edge_w[k]);
         always_ff @(posedge clk) begin
            if (!rst_n)          acc_q[k] <= '0;
            else if (win_end_o)  acc_q[k] <= '0;
            else if (tally_i)    acc_q[k] <= sum_o[k];
         end
      end
   endgenerate
endmodule

// File: rtl/os4_phase_pick.sv
module os4_phase_pick #(
   parameter int CW = 7
) (
   input  logic [os4_pkg::NPH-1:0][CW-1:0]  sum_i,
   input  os4_pkg::ph_t                     cur_i,
   output os4_pkg::ph_t                     nxt_o
);
   os4_pkg::ph_t  busy_w;
   logic [CW-1:0] best_w;
   logic          any_w;

   always_comb begin
      busy_w = '0;
      best_w = sum_i[0];
      any_w  = 1'b0;
      for (int k = 0; k < os4_pkg::NPH; k++) begin
         if (sum_i[k] != '0) any_w = 1'b1;
         if (sum_i[k] > best_w) begin
            best_w = sum_i[k];
            busy_w = os4_pkg::ph_t'(k);
         end
      end
      nxt_o = any_w ? os4_pkg::ph_step(cur_i, os4_pkg::ph_t'(busy_w + 2'd2)) : cur_i;
   end
endmodule

// File: rtl/os4_emit.sv
module os4_emit (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire_i,
   input  logic [os4_pkg::NPH-1:0]  s1_i,
   input  logic [os4_pkg::NPH-1:0]  s2_i,
   input  os4_pkg::ph_t             sel_i,
   input  os4_pkg::ph_t             last_i,
   output logic [1:0]               bit_o,
   output logic [1:0]               cnt_o,
   output logic                     vld_o
);
   logic fwd_wrap, bwd_wrap;
   assign fwd_wrap = (sel_i == 2'd0) && (last_i == 2'd3);
   assign bwd_wrap = (sel_i == 2'd3) && (last_i == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_o <= '0;
         cnt_o <= '0;
         vld_o <= 1'b0;
      end else if (!fire_i) begin
         cnt_o <= '0;
         vld_o <= 1'b0;
      end else if (fwd_wrap) begin
         cnt_o <= 2'd0;
         vld_o <= 1'b0;
      end else if (bwd_wrap) begin
         bit_o <= {s1_i[3], s2_i[3]};
         cnt_o <= 2'd2;
         vld_o <= 1'b1;
      end else begin
         bit_o <= {1'b0, s1_i[sel_i]};
         cnt_o <= 2'd1;
         vld_o <= 1'b1;
      end
   end
endmodule

// File: rtl/os4_bit_aligner.sv
module os4_bit_aligner #(
   parameter int           WIN     = 64,
   parameter logic [1:0]   INIT_PH = 2'd2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ph_vld_i,
   input  logic [3:0]  ph_smp_i,
   output logic [1:0]  bit_o,
   output logic [1:0]  bit_cnt_o,
   output logic        bit_vld_o,
   output logic [1:0]  phase_o
);
   localparam int CW = $clog2(WIN + 1);

   generate
      if (WIN < 4) begin : g_bad_win
         $error("os4_bit_aligner: WIN must be at least 4");
      end
   endgenerate

   logic [3:0]                       s1_q, s2_q;
   logic                             h1_q;
   os4_pkg::ph_t                     sel_q, last_q, nxt_w;
   logic                             fire_w, win_end_w;
   logic [os4_pkg::NPH-1:0][CW-1:0]  sum_w;

   assign fire_w = ph_vld_i && h1_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= '0;
         s2_q <= '0;
         h1_q <= 1'b0;
      end else if (ph_vld_i) begin
         s1_q <= ph_smp_i;
         s2_q <= s1_q;
         h1_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= INIT_PH;
         last_q <= INIT_PH;
      end else begin
         if (fire_w)    last_q <= sel_q;
         if (win_end_w) sel_q  <= nxt_w;
      end
   end

   os4_edge_tally #(.WIN(WIN), .CW(CW)) u_tally (
      .clk       (clk),
      .rst_n     (rst_n),
      .tally_i   (fire_w),
      .cur_i     (ph_smp_i),
      .prev3_i   (s1_q[3]),
      .win_end_o (win_end_w),
      .sum_o     (sum_w)
   );

   os4_phase_pick #(.CW(CW)) u_pick (
      .sum_i (sum_w),
      .cur_i (sel_q),
      .nxt_o (nxt_w)
   );

   os4_emit u_emit (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire_w),
      .s1_i   (s1_q),
      .s2_i   (s2_q),
      .sel_i  (sel_q),
      .last_i (last_q),
      .bit_o  (bit_o),
      .cnt_o  (bit_cnt_o),
      .vld_o  (bit_vld_o)
   );

   assign phase_o = sel_q;
endmodule

// File: rtl/os4_bit_aligner_chk.sv
module os4_bit_aligner_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ph_vld_i,
   input logic [1:0]  bit_cnt_o,
   input logic        bit_vld_o,
   input logic [1:0]  phase_o
);
   // R4: any change of phase is a single step modulo 4
   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o != $past(phase_o)) |->
         ((2'(phase_o - $past(phase_o)) == 2'd1) || (2'(phase_o - $past(phase_o)) == 2'd3)));

   // R9: an idle cycle emits nothing next cycle
   a_r9_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_vld_i |=> (bit_cnt_o == 2'd0));

   // R9: an idle cycle leaves the phase alone
   a_r9_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_vld_i |=> $stable(phase_o));

   // R8: a double emission happens only with phase 3 selected
   a_r8_double_at_three: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt_o == 2'd2) |-> (phase_o == 2'd3));

   // R6: count never exceeds two
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt_o != 2'd3);

   // R10: valid flag tracks the count
   a_r10_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o == (bit_cnt_o != 2'd0));
endmodule

bind os4_bit_aligner os4_bit_aligner_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ph_vld_i  (ph_vld_i),
   .bit_cnt_o (bit_cnt_o),
   .bit_vld_o (bit_vld_o),
   .phase_o   (phase_o)
);

// File: tb/os4_bit_aligner_tb.sv
module os4_bit_aligner_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ph_vld_i;
   logic [3:0] ph_smp_i;
   logic [1:0] bit_o, bit_cnt_o, phase_o;
   logic       bit_vld_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   os4_bit_aligner #(.WIN(WIN), .INIT_PH(2'd2)) u_dut (
      .clk(clk), .rst_n(rst_n), .ph_vld_i(ph_vld_i), .ph_smp_i(ph_smp_i),
      .bit_o(bit_o), .bit_cnt_o(bit_cnt_o), .bit_vld_o(bit_vld_o), .phase_o(phase_o)
   );

   // frame-level model of the requirements
   bit       m_h1;
   bit [3:0] m_s1, m_s2;
   bit [1:0] m_sel, m_last;
   int       m_acc [4];
   int       m_w;
   bit [1:0] e_bits, e_cnt;
   bit       prevd;

   function automatic bit [1:0] step_to(bit [1:0] cur, bit [1:0] tgt);
      bit [1:0] d = tgt - cur;
      if (d == 0) return cur;
      if (d == 3) return cur - 2'd1;
      return cur + 2'd1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_h1 = 0; m_s1 = 0; m_s2 = 0; m_sel = 2; m_last = 2; m_w = 0;
      foreach (m_acc[k]) m_acc[k] = 0;
   endtask

   task automatic step(input bit v, input bit [3:0] smp);
      string rq_cnt, rq_ph;
      bit [1:0] old_sel;
      int t [4];
      @(negedge clk);
      ph_vld_i = v;
      ph_smp_i = smp;
      e_cnt  = 0;
      rq_cnt = v ? "R6" : "R9";
      rq_ph  = v ? "R3" : "R9";
      if (v && m_h1) begin
         old_sel = m_sel;
         if (m_sel == 0 && m_last == 3) begin e_cnt = 0; rq_cnt = "R7"; end
         else if (m_sel == 3 && m_last == 0) begin
            e_cnt = 2; e_bits = {m_s1[3], m_s2[3]}; rq_cnt = "R8";
         end else begin e_cnt = 1; e_bits[0] = m_s1[m_sel]; end
         m_last = m_sel;
         t[0] = int'(m_s1[3] ^ smp[0]);
         for (int k = 1; k < 4; k++) t[k] = int'(smp[k-1] ^ smp[k]);
         for (int k = 0; k < 4; k++) m_acc[k] += t[k];    // R2 tally
         if (m_w == WIN-1) begin
            int best = 0;
            int tot  = 0;
            for (int k = 0; k < 4; k++) begin
               tot += m_acc[k];
               if (m_acc[k] > m_acc[best]) best = k;
            end
            if (tot == 0) rq_ph = "R5";
            else m_sel = step_to(old_sel, 2'(best + 2));
            foreach (m_acc[k]) m_acc[k] = 0;
            m_w = 0;
         end else m_w++;
      end
      if (v) begin m_s2 = m_s1; m_s1 = smp; m_h1 = 1; end
      @(posedge clk);
      #1;
      chk(bit_cnt_o == e_cnt, rq_cnt, bit_cnt_o, e_cnt);
      chk(bit_vld_o == (e_cnt != 0), "R10", bit_vld_o, e_cnt != 0);
      if (e_cnt != 0) chk(bit_o[0] == e_bits[0], rq_cnt, bit_o[0], e_bits[0]);
      if (e_cnt == 2) chk(bit_o[1] == e_bits[1], "R8", bit_o[1], e_bits[1]);
      chk(phase_o == m_sel, rq_ph, phase_o, m_sel);
   endtask

   // one frame whose bit boundary sits at position off+jit
   task automatic frame(input int off, input int jit, input bit hold, input bit gaps);
      bit [3:0] s;
      bit nd;
      int ep = off + jit;
      if (ep < 0) ep = 0;
      if (ep > 3) ep = 3;
      nd = hold ? prevd : (($urandom % 4) != 0 ? ~prevd : prevd);
      for (int k = 0; k < 4; k++) s[k] = (k < ep) ? prevd : nd;
      prevd = nd;
      if (gaps && ($urandom % 5) == 0) step(1'b0, 4'($urandom));
      step(1'b1, s);
   endtask

   task automatic run(input int off, input int nwin, input bit hold);
      for (int i = 0; i < nwin * WIN; i++) frame(off, 0, hold, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      rst_n = 0; ph_vld_i = 0; ph_smp_i = 0; prevd = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      chk(phase_o == 2'd2, "R1", phase_o, 2);
      chk(bit_cnt_o == 0 && bit_vld_o == 0, "R1", bit_cnt_o, 0);
      step(1'b0, 4'hF);                      // R9 idle after reset
      frame(0, 0, 1'b0, 1'b0);               // priming frame, not tallied
      run(0, 2, 1'b0);  chk(phase_o == 2'd2, "R2 R3 edges at 0", phase_o, 2);
      run(1, 1, 1'b0);  chk(phase_o == 2'd3, "R3 R4 edges at 1", phase_o, 3);
      run(3, 1, 1'b0);  chk(phase_o == 2'd0, "R4 R7 opposite step wraps 3->0", phase_o, 0);
      run(3, 1, 1'b0);  chk(phase_o == 2'd1, "R4 edges at 3", phase_o, 1);
      run(2, 1, 1'b0);  chk(phase_o == 2'd0, "R4 down step", phase_o, 0);
      run(1, 1, 1'b0);  chk(phase_o == 2'd3, "R8 wrap 0->3", phase_o, 3);
      run(1, 1, 1'b1);  chk(phase_o == 2'd3, "R5 quiet window", phase_o, 3);
      for (int w = 0; w < 60; w++) begin
         int off = int'($urandom % 4);
         for (int i = 0; i < WIN; i++) begin
            int jit = (($urandom % 4) == 0) ? int'($urandom % 3) - 1 : 0;
            frame(off, jit, 1'b0, 1'b1);
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule